// File: doc/BRIEF.md
# Two-stage watchdog timer

This block is a countdown watchdog that gives software two chances to recover before the system is reset. When it is armed, a first countdown runs from a programmable preload. If nothing services the watchdog before that countdown ends, the block sends a one-cycle interrupt request of a configurable kind. It then starts a second countdown from a separate preload. If the second countdown also ends, the block raises a one-cycle system-reset request and sets a sticky cause flag. The flag tells boot code after the reset that the watchdog caused it.

Each countdown lasts its 20-bit preload shifted left by one of two prescale amounts. The block holds its own copy of the control and configuration fields, which the surrounding bus logic loads through write strobes. A lock bit freezes the run controls. A second-stage expiry that requests a reset returns every field to its default. The cause flag is cleared only by a power-on reset or by an explicit clear input, so it survives the block's own reset.

Top module: `wdt_two_stage`

## Requirements
- R1: While rst_ni is low, and after it is released, the block is disabled and unlocked, in stage one, with reboot on, free-run off, the slow prescale, interrupt kind 0 and both preloads at 0xFFFFF. irq_o and rst_req_o are low. rst_ni does not change prev_wdt_o.
- R2: A stage lasts D = max(1, preload << S) clock cycles, where S = 15 when cfg_fast_i was written 0 and S = 5 when it was written 1. If the arming write is sampled at edge E, irq_o is high in the cycle after edge E+D1 and rst_req_o is high in the cycle after edge E+D1+D2.
- R3: A control write starts stage one only if it takes the enable from 0 to 1. Writing enable = 1 while the block is already enabled does not restart the countdown.
- R4: A control write with enable = 0 stops counting at once. No interrupt or reset request follows, and stage_o keeps its value. A stop in the same cycle as an expiry wins over the expiry.
- R5: While the block is enabled, kick_i restarts stage one from the first preload, from either stage, including after counting has stopped at the end of stage two. While the block is disabled, kick_i has no effect.
- R6: When stage one expires, stage_o goes to 1 (stage two) and irq_o pulses for exactly one cycle. No pulse is made when the kind is 3. irq_kind_o shows the configured kind: 0 for a normal interrupt, 2 for a system-management interrupt, 3 for none.
- R7: When stage two expires with reboot on, rst_req_o pulses for one cycle and prev_wdt_o is set. All configuration returns to the R1 defaults, so the block is disabled, unlocked and at kind 0.
- R8: When stage two expires with reboot off, there is no reset request and the flag does not change. With free-run on, stage one restarts (stage_o back to 0). With free-run off, counting stops and stage_o stays 1.
- R9: After a control write with the lock bit set, later control writes are ignored until rst_ni or a reboot expiry.
- R10: prev_wdt_o is cleared only by por_ni or flag_clr_i. A set caused by a reboot expiry wins over a clear in the same cycle.
- R11: A kick that arrives in the same cycle as a stage-one expiry wins. No interrupt pulse is made and the block stays in stage one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| por_ni | input | 1 | Asynchronous active-low power-on reset, clears the cause flag |
| ctl_we_i | input | 1 | Write strobe for enable, lock and free-run |
| ctl_en_i | input | 1 | Enable value |
| ctl_lock_i | input | 1 | Lock value |
| ctl_free_i | input | 1 | Free-run value |
| cfg_we_i | input | 1 | Write strobe for reboot, prescale and kind |
| cfg_reboot_i | input | 1 | 1 = request reset on stage-two expiry |
| cfg_fast_i | input | 1 | 1 = fast prescale (shift 5), 0 = slow (shift 15) |
| cfg_kind_i | input | 2 | Interrupt kind: 0 normal, 2 system-management, 3 none |
| pre1_we_i | input | 1 | Write strobe for the stage-one preload |
| pre2_we_i | input | 1 | Write strobe for the stage-two preload |
| pre_val_i | input | 20 | Preload write data |
| kick_i | input | 1 | Keep-alive pulse |
| flag_clr_i | input | 1 | Clears the cause flag |
| irq_o | output | 1 | One-cycle stage-one interrupt request |
| irq_kind_o | output | 2 | Configured interrupt kind |
| rst_req_o | output | 1 | One-cycle system-reset request |
| stage_o | output | 1 | 0 = stage one, 1 = stage two |
| prev_wdt_o | output | 1 | Sticky flag: a watchdog reset has occurred |

## Verification
The bench sweeps small preload pairs in the fast prescale, including zero. This catches an off-by-one stage length or a zero preload that wraps to a huge count, because either one moves the measured interrupt and reset cycles. It also checks a rewrite of the enable in mid-count, a kick exactly on the expiry edge, and a stop while in stage two. A design that re-arms on level, lets the expiry through, or drops back to stage one would each move or add a pulse. Further checks look for a lock that leaks a disable, a reboot that leaves the kind or the enable set, a cause flag that is lost to rst_ni or to a clear in the same cycle, and a free-run loop whose second interrupt arrives at the wrong cycle.

// File: rtl/wdt_two_stage_pkg.sv
package wdt_two_stage_pkg;

  typedef enum logic [1:0] {
    KIND_IRQ  = 2'd0,
    KIND_ALT  = 2'd1,
    KIND_SMI  = 2'd2,
    KIND_NONE = 2'd3
  } irq_kind_e;

  typedef enum logic {
    STG_ONE = 1'b0,
    STG_TWO = 1'b1
  } stage_e;

  typedef struct packed {
    logic      en;
    logic      lock;
    logic      free;
    logic      reboot;
    logic      fast;
    irq_kind_e kind;
  } wdt_cfg_t;

  localparam wdt_cfg_t CFG_DEFAULT = '{
    en:     1'b0,
    lock:   1'b0,
    free:   1'b0,
    reboot: 1'b1,
    fast:   1'b0,
    kind:   KIND_IRQ
  };

endpackage

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
  import wdt_two_stage_pkg::*;
#(
  parameter int PRE_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_clr_i,
  input  logic             ctl_we_i,
  input  logic             ctl_en_i,
  input  logic             ctl_lock_i,
  input  logic             ctl_free_i,
  input  logic             cfg_we_i,
  input  logic             cfg_reboot_i,
  input  logic             cfg_fast_i,
  input  logic [1:0]       cfg_kind_i,
  input  logic             pre1_we_i,
  input  logic             pre2_we_i,
  input  logic [PRE_W-1:0] pre_val_i,
  output wdt_cfg_t         cfg_o,
  output logic [PRE_W-1:0] pre1_o,
  output logic [PRE_W-1:0] pre2_o,
  output logic             start_o,
  output logic             stop_o
);

  localparam logic [PRE_W-1:0] PRE_DEFAULT = '1;

  wdt_cfg_t         cfg_q;
  logic [PRE_W-1:0] pre1_q, pre2_q;
  logic             ctl_ok;

  assign ctl_ok  = ctl_we_i && !cfg_q.lock;
  assign start_o = ctl_ok && ctl_en_i && !cfg_q.en;
  assign stop_o  = ctl_ok && !ctl_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CFG_DEFAULT;
      pre1_q <= PRE_DEFAULT;
      pre2_q <= PRE_DEFAULT;
    end else if (soft_clr_i) begin
      cfg_q  <= CFG_DEFAULT;
      pre1_q <= PRE_DEFAULT;
      pre2_q <= PRE_DEFAULT;
    end else begin
      if (ctl_ok) begin
        cfg_q.en   <= ctl_en_i;
        cfg_q.lock <= ctl_lock_i;
        cfg_q.free <= ctl_free_i;
      end
      if (cfg_we_i) begin
        cfg_q.reboot <= cfg_reboot_i;
        cfg_q.fast   <= cfg_fast_i;
        cfg_q.kind   <= irq_kind_e'(cfg_kind_i);
      end
      if (pre1_we_i) pre1_q <= pre_val_i;
      if (pre2_we_i) pre2_q <= pre_val_i;
    end
  end

  assign cfg_o  = cfg_q;
  assign pre1_o = pre1_q;
  assign pre2_o = pre2_q;

  // R9
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.lock && !soft_clr_i |=> cfg_q.lock && $stable(cfg_q.en) && $stable(cfg_q.free));

  // R9
  lock_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.lock |-> !start_o && !stop_o);

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CNT_W = 35
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             running_o,
  output logic             expire_o
);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (halt_i) begin
      run_q <= 1'b0;
    end else if (load_i) begin
      run_q <= 1'b1;
      cnt_q <= load_val_i;
    end else if (run_q && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign running_o = run_q;
  assign expire_o  = run_q && (cnt_q == '0);

  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && cnt_q != '0 && !halt_i && !load_i |=> run_q && cnt_q == $past(cnt_q) - CNT_W'(1));

  // R4
  halt_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> !run_q && !expire_o);

endmodule

// File: rtl/wdt_stage_ctl.sv
module wdt_stage_ctl
  import wdt_two_stage_pkg::*;
#(
  parameter int PRE_W   = 20,
  parameter int SLOW_SH = 15,
  parameter int FAST_SH = 5,
  parameter int CNT_W   = PRE_W + SLOW_SH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  wdt_cfg_t         cfg_i,
  input  logic [PRE_W-1:0] pre1_i,
  input  logic [PRE_W-1:0] pre2_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             kick_i,
  input  logic             flag_clr_i,
  input  logic             expire_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             halt_o,
  output logic             soft_clr_o,
  output stage_e           stage_o,
  output logic             irq_o,
  output logic             rst_req_o,
  output logic             flag_o
);

  function automatic logic [CNT_W-1:0] stage_ticks(input logic [PRE_W-1:0] pre,
                                                   input logic fast);
    logic [CNT_W-1:0] wide;
    wide = fast ? (CNT_W'(pre) << FAST_SH) : (CNT_W'(pre) << SLOW_SH);
    return (pre == '0) ? '0 : wide - CNT_W'(1);
  endfunction

  stage_e stage_q;
  logic   irq_q, rst_q, flag_q;
  logic   kick_ok, ld_one, ld_two, irq_ev, rst_ev;

  assign kick_ok = kick_i && cfg_i.en;

  always_comb begin
    ld_one     = 1'b0;
    ld_two     = 1'b0;
    halt_o     = 1'b0;
    soft_clr_o = 1'b0;
    irq_ev     = 1'b0;
    rst_ev     = 1'b0;
    if (stop_i) begin
      halt_o = 1'b1;
    end else if (start_i || kick_ok) begin
      ld_one = 1'b1;
    end else if (expire_i) begin
      if (stage_q == STG_ONE) begin
        ld_two = 1'b1;
        irq_ev = (cfg_i.kind != KIND_NONE);
      end else if (cfg_i.reboot) begin
        halt_o     = 1'b1;
        soft_clr_o = 1'b1;
        rst_ev     = 1'b1;
      end else if (cfg_i.free) begin
        ld_one = 1'b1;
      end else begin
        halt_o = 1'b1;
      end
    end
  end

  assign load_o     = ld_one || ld_two;
  assign load_val_o = ld_two ? stage_ticks(pre2_i, cfg_i.fast) : stage_ticks(pre1_i, cfg_i.fast);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= STG_ONE;
      irq_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      irq_q <= irq_ev;
      rst_q <= rst_ev;
      if (soft_clr_o || ld_one) stage_q <= STG_ONE;
      else if (ld_two)          stage_q <= STG_TWO;
    end
  end

  // cause flag lives on the power-on reset only
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)         flag_q <= 1'b0;
    else if (rst_ev)     flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign stage_o   = stage_q;
  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;
  assign flag_o    = flag_q;

  // R6
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);

  // R6
  irq_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(cfg_i.kind) != KIND_NONE && stage_q == STG_TWO);

  // R7
  rst_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    rst_q |-> flag_q && stage_q == STG_ONE);

  // R10
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    flag_q && !flag_clr_i |=> flag_q);

  // R10
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    $rose(flag_q) |-> rst_q);

  // R11
  kick_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i && kick_i && cfg_i.en && !stop_i |=> !irq_q && !rst_q && stage_q == STG_ONE);

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_two_stage_pkg::*;
#(
  parameter int PRE_W   = 20,
  parameter int SLOW_SH = 15,
  parameter int FAST_SH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             ctl_we_i,
  input  logic             ctl_en_i,
  input  logic             ctl_lock_i,
  input  logic             ctl_free_i,
  input  logic             cfg_we_i,
  input  logic             cfg_reboot_i,
  input  logic             cfg_fast_i,
  input  logic [1:0]       cfg_kind_i,
  input  logic             pre1_we_i,
  input  logic             pre2_we_i,
  input  logic [PRE_W-1:0] pre_val_i,
  input  logic             kick_i,
  input  logic             flag_clr_i,
  output logic             irq_o,
  output logic [1:0]       irq_kind_o,
  output logic             rst_req_o,
  output logic             stage_o,
  output logic             prev_wdt_o
);

  localparam int CNT_W = PRE_W + SLOW_SH;

  wdt_cfg_t         cfg;
  logic [PRE_W-1:0] pre1, pre2;
  logic             start, stop, soft_clr;
  logic             load, halt, running, expire;
  logic [CNT_W-1:0] load_val;
  stage_e           stage;

  wdt_cfg_regs #(.PRE_W(PRE_W)) i_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .soft_clr_i   (soft_clr),
    .ctl_we_i     (ctl_we_i),
    .ctl_en_i     (ctl_en_i),
    .ctl_lock_i   (ctl_lock_i),
    .ctl_free_i   (ctl_free_i),
    .cfg_we_i     (cfg_we_i),
    .cfg_reboot_i (cfg_reboot_i),
    .cfg_fast_i   (cfg_fast_i),
    .cfg_kind_i   (cfg_kind_i),
    .pre1_we_i    (pre1_we_i),
    .pre2_we_i    (pre2_we_i),
    .pre_val_i    (pre_val_i),
    .cfg_o        (cfg),
    .pre1_o       (pre1),
    .pre2_o       (pre2),
    .start_o      (start),
    .stop_o       (stop)
  );

  wdt_stage_ctl #(
    .PRE_W   (PRE_W),
    .SLOW_SH (SLOW_SH),
    .FAST_SH (FAST_SH),
    .CNT_W   (CNT_W)
  ) i_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .por_ni     (por_ni),
    .cfg_i      (cfg),
    .pre1_i     (pre1),
    .pre2_i     (pre2),
    .start_i    (start),
    .stop_i     (stop),
    .kick_i     (kick_i),
    .flag_clr_i (flag_clr_i),
    .expire_i   (expire),
    .load_o     (load),
    .load_val_o (load_val),
    .halt_o     (halt),
    .soft_clr_o (soft_clr),
    .stage_o    (stage),
    .irq_o      (irq_o),
    .rst_req_o  (rst_req_o),
    .flag_o     (prev_wdt_o)
  );

  wdt_countdown #(.CNT_W(CNT_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .halt_i     (halt),
    .load_i     (load),
    .load_val_i (load_val),
    .running_o  (running),
    .expire_o   (expire)
  );

  assign irq_kind_o = cfg.kind;
  assign stage_o    = stage;

  // R4
  run_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running |-> cfg.en);

  // R7
  reboot_defaults_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !cfg.en && !cfg.lock && cfg.kind == KIND_IRQ && !running);

endmodule

// File: tb/test_wdt_two_stage.sv
`timescale 1ns/1ps
module test_wdt_two_stage;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0, por_ni = 1'b0;
  logic        ctl_we_i = 0, ctl_en_i = 0, ctl_lock_i = 0, ctl_free_i = 0;
  logic        cfg_we_i = 0, cfg_reboot_i = 0, cfg_fast_i = 0;
  logic [1:0]  cfg_kind_i = 0;
  logic        pre1_we_i = 0, pre2_we_i = 0;
  logic [19:0] pre_val_i = 0;
  logic        kick_i = 0, flag_clr_i = 0;
  logic        irq_o, rst_req_o, stage_o, prev_wdt_o;
  logic [1:0]  irq_kind_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int irq_k, irq_k2, rst_k, irq_n, rst_n, st1_k, st0_k, irq_kind_s, irq_stage, rst_flag, stage_first;

  always #2.5 clk_i = ~clk_i;

  wdt_two_stage i_wdt_two_stage (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic en, input logic lk, input logic fr);
    ctl_we_i = 1; ctl_en_i = en; ctl_lock_i = lk; ctl_free_i = fr;
    @(negedge clk_i);
    ctl_we_i = 0;
  endtask

  task automatic wr_cfg(input logic rb, input logic fa, input logic [1:0] kd);
    cfg_we_i = 1; cfg_reboot_i = rb; cfg_fast_i = fa; cfg_kind_i = kd;
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  task automatic wr_pre(input int sel, input logic [19:0] v);
    pre_val_i = v;
    if (sel == 1) pre1_we_i = 1; else pre2_we_i = 1;
    @(negedge clk_i);
    pre1_we_i = 0; pre2_we_i = 0;
  endtask

  task automatic kick();
    kick_i = 1;
    @(negedge clk_i);
    kick_i = 0;
  endtask

  task automatic window(input int n);
    irq_k = 0; irq_k2 = 0; rst_k = 0; irq_n = 0; rst_n = 0; st1_k = 0; st0_k = 0;
    irq_kind_s = -1; irq_stage = -1; rst_flag = -1;
    stage_first = int'(stage_o);
    for (int k = 1; k <= n; k++) begin
      if (irq_o) begin
        irq_n++;
        if (irq_k == 0) begin irq_k = k; irq_kind_s = int'(irq_kind_o); irq_stage = int'(stage_o); end
        else if (irq_k2 == 0) irq_k2 = k;
      end
      if (rst_req_o) begin
        rst_n++;
        if (rst_k == 0) begin rst_k = k; rst_flag = int'(prev_wdt_o); end
      end
      if (stage_o && st1_k == 0) st1_k = k;
      if (!stage_o && st1_k != 0 && st0_k == 0) st0_k = k;
      @(negedge clk_i);
    end
  endtask

  function automatic int dur(input int p, input int sh);
    return (p == 0) ? 1 : (p << sh);
  endfunction

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 120000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int p2s[3] = '{0, 1, 3};
    repeat (3) @(negedge clk_i);
    rst_ni = 1; por_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 irq", irq_o, 0);
    chk("R1 rst_req", rst_req_o, 0);
    chk("R1 stage", stage_o, 0);
    chk("R1 kind", irq_kind_o, 0);
    chk("R1 flag", prev_wdt_o, 0);

    // R2/R7 sweep of stage lengths, fast prescale, reboot on
    for (int p1 = 0; p1 < 4; p1++) begin
      for (int j = 0; j < 3; j++) begin
        int d1, d2;
        d1 = dur(p1, 5); d2 = dur(p2s[j], 5);
        wr_pre(1, 20'(p1)); wr_pre(2, 20'(p2s[j]));
        wr_cfg(1, 1, 0);
        wr_ctl(1, 0, 0);
        window(d1 + d2 + 4);
        chk("R2 irq cycle", irq_k, d1 + 1);
        chk("R2 rst_req cycle", rst_k, d1 + d2 + 1);
        chk("R6 single irq", irq_n, 1);
        chk("R7 single rst_req", rst_n, 1);
        chk("R7 flag at reset", rst_flag, 1);
        chk("R6 stage two at irq", irq_stage, 1);
        flag_clr_i = 1; @(negedge clk_i); flag_clr_i = 0;
        chk("R10 clear", prev_wdt_o, 0);
      end
    end

    // R6/R8 kind 2, reboot off, free-run off
    wr_pre(1, 1); wr_pre(2, 1);
    wr_cfg(0, 1, 2);
    wr_ctl(1, 0, 0);
    window(75);
    chk("R6 irq cycle", irq_k, 33);
    chk("R6 kind smi", irq_kind_s, 2);
    chk("R8 no rst_req", rst_n, 0);
    chk("R8 flag unchanged", prev_wdt_o, 0);
    chk("R8 stage held", stage_o, 1);
    kick();
    window(40);
    chk("R5 kick after stop stage", stage_first, 0);
    chk("R5 kick after stop irq", irq_k, 33);
    wr_ctl(0, 0, 0);

    // R6/R8 kind 3 free-run
    wr_cfg(0, 1, 3);
    wr_ctl(1, 0, 1);
    window(100);
    chk("R6 kind none no irq", irq_n, 0);
    chk("R6 stage two entry", st1_k, 33);
    chk("R8 free-run back to one", st0_k, 65);
    chk("R8 free-run no rst_req", rst_n, 0);
    wr_ctl(0, 0, 0);

    // R8 free-run periodic irq
    wr_cfg(0, 1, 0);
    wr_ctl(1, 0, 1);
    window(100);
    chk("R8 first irq", irq_k, 33);
    chk("R8 second irq", irq_k2, 97);
    wr_ctl(0, 0, 0);

    // R4 stop in stage one, then in stage two
    wr_ctl(1, 0, 0);
    window(10);
    wr_ctl(0, 0, 0);
    window(80);
    chk("R4 no irq after stop", irq_n, 0);
    chk("R4 stage one held", stage_o, 0);
    wr_ctl(1, 0, 0);
    window(40);
    wr_ctl(0, 0, 0);
    window(50);
    chk("R4 stage two held", stage_first, 1);
    chk("R4 no rst_req", rst_n, 0);
    kick();
    window(3);
    chk("R5 kick ignored when disabled", stage_first, 1);

    // R3 rewrite of enable does not restart
    wr_ctl(1, 0, 0);
    window(10);
    wr_ctl(1, 0, 0);
    window(40);
    chk("R3 irq at original time", irq_k, 22);
    wr_ctl(0, 0, 0);

    // R5 kick restarts stage one
    wr_ctl(1, 0, 0);
    window(20);
    kick();
    window(40);
    chk("R5 irq after kick", irq_k, 33);
    wr_ctl(0, 0, 0);

    // R11 kick on the expiry edge
    wr_ctl(1, 0, 0);
    window(31);
    kick();
    window(40);
    chk("R11 stage stays one", stage_first, 0);
    chk("R11 irq deferred", irq_k, 33);
    wr_ctl(0, 0, 0);

    // R9 lock, R7 defaults, R10 set wins over clear
    wr_cfg(1, 1, 2);
    flag_clr_i = 1;
    wr_ctl(1, 1, 0);
    window(5);
    wr_ctl(0, 0, 0);
    window(80);
    chk("R9 irq despite disable", irq_k, 27);
    chk("R9 kind at irq", irq_kind_s, 2);
    chk("R9 rst_req cycle", rst_k, 59);
    chk("R10 set wins over clear", rst_flag, 1);
    flag_clr_i = 0;
    chk("R10 clear after set", prev_wdt_o, 0);
    chk("R7 kind default", irq_kind_o, 0);
    window(60);
    chk("R7 disabled after reboot", irq_n + rst_n, 0);
    wr_pre(1, 0); wr_pre(2, 0);
    wr_ctl(1, 0, 0);
    window(5);
    chk("R7 unlocked after reboot", rst_k, 3);
    chk("R7 flag set", prev_wdt_o, 1);

    // R10/R1 flag survives rst_ni, cleared by por_ni
    rst_ni = 0; @(negedge clk_i); rst_ni = 1; @(negedge clk_i);
    chk("R10 flag survives rst_ni", prev_wdt_o, 1);
    chk("R1 stage after rst_ni", stage_o, 0);
    por_ni = 0; @(negedge clk_i); por_ni = 1; @(negedge clk_i);
    chk("R10 por clears flag", prev_wdt_o, 0);

    // R1 rst_ni during a run disables
    wr_pre(1, 1); wr_pre(2, 1);
    wr_cfg(1, 1, 2);
    wr_ctl(1, 0, 0);
    window(5);
    rst_ni = 0; @(negedge clk_i); rst_ni = 1; @(negedge clk_i);
    chk("R1 kind after rst_ni", irq_kind_o, 0);
    window(80);
    chk("R1 disabled after rst_ni", irq_n, 0);

    // R2/R1 slow prescale is the default
    wr_pre(1, 1); wr_pre(2, 0);
    wr_ctl(1, 0, 0);
    window(32775);
    chk("R2 slow irq cycle", irq_k, 32769);
    chk("R2 slow rst_req cycle", rst_k, 32770);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule